// File: doc/BRIEF.md
# Single-Bus Accumulator Datapath

This block is the register-transfer datapath of a small stored-program machine. One shared bus carries every transfer. Five sources can drive it, each through its own output enable: the accumulator, a constant source that gives 0 or 1, the program counter, an input port, and an internal word memory. Registers on the bus side capture the bus value on the rising clock edge. These are the adder buffer, the memory address register and the program counter.

Arithmetic has only one path: the accumulator is loaded with the buffer value plus the bus, or minus the bus when the subtract strobe is high. To make a plain load, a sequencer first puts zero into the buffer and then adds. A zero flag reports an empty accumulator, which supports conditional jumps. A separate sequencer drives every strobe and is not part of this block.

Top module: `acc_datapath`

## Requirements
- R1: An active-low asynchronous reset clears the accumulator, adder buffer, address register and program counter to zero. When no output enable is high, the bus reads zero.
- R2: With its enable high, the constant source drives 0 when const_sel_i is 0 and 1 when const_sel_i is 1.
- R3: On a clock edge with ld_abr_i high, the buffer captures the bus. On an edge with ld_acc_i high and sub_i low, the accumulator becomes buffer plus bus, modulo 256.
- R4: On an edge with ld_acc_i and sub_i both high, the accumulator becomes buffer minus bus, modulo 256.
- R5: eqz_o is high exactly when the accumulator holds zero.
- R6: On an edge, ld_pc_i loads the program counter from the bus. inc_pc_i alone adds one, wrapping from 255 to 0. When both are high, the load wins.
- R7: ld_mar_i captures the bus into the address register. we_mem_i writes the bus into the word at that address on the edge. oe_mem_i drives the addressed word onto the bus. Words at other addresses are unchanged.
- R8: With oe_port_i high, the bus carries port_data_i.
- R9: oe_acc_i drives the accumulator onto the bus and oe_pc_i drives the program counter. At most one output enable may be high in a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_abr_i | input | 1 | Capture bus into adder buffer |
| sub_i | input | 1 | Adder subtracts the bus |
| ld_acc_i | input | 1 | Load accumulator from adder |
| oe_acc_i | input | 1 | Accumulator drives bus |
| oe_const_i | input | 1 | Constant source drives bus |
| const_sel_i | input | 1 | Constant value: 0 or 1 |
| oe_pc_i | input | 1 | Program counter drives bus |
| ld_pc_i | input | 1 | Load program counter from bus |
| inc_pc_i | input | 1 | Increment program counter |
| we_mem_i | input | 1 | Write bus into addressed word |
| oe_port_i | input | 1 | Input port drives bus |
| oe_mem_i | input | 1 | Addressed word drives bus |
| ld_mar_i | input | 1 | Capture bus into address register |
| port_data_i | input | 8 | Input port value |
| bus_o | output | 8 | Shared bus value |
| acc_o | output | 8 | Accumulator |
| pc_o | output | 8 | Program counter |
| mar_o | output | 8 | Memory address register |
| eqz_o | output | 1 | Accumulator is zero |

## Verification
Two cases put functions into the same cycle. In the first, load and increment of the program counter are both asserted, with the constant 1 on the bus and the counter at 0xF6. The only correct result is 0x01, so an increment that wins is caught. In the second, the buffer is loaded from the bus in one cycle and the accumulator adds or subtracts through that buffer in the next. These cases are run across wrap-around, with 1 minus 12 expected to give 0xF5 and 0xF6 plus 12 expected to give 0x02, so a reversed operand order or a lost carry is caught. A memory write and a later read-back are also made at two addresses to show that the words stay separate.

// File: rtl/acc_dp_pkg.sv
package acc_dp_pkg;
  // bus source index; order is the bit order of the enable vector
  typedef enum int unsigned {
    SRC_ACC   = 0,
    SRC_CONST = 1,
    SRC_PC    = 2,
    SRC_PORT  = 3,
    SRC_MEM   = 4
  } bus_src_e;

  localparam int unsigned NUM_SRC = 5;
endpackage

// File: rtl/dp_bus_mux.sv
module dp_bus_mux #(
  parameter int unsigned W   = 8,
  parameter int unsigned NSRC = 5
) (
  input  logic [NSRC-1:0]        oe_i,
  input  logic [NSRC-1:0][W-1:0] src_i,
  output logic [W-1:0]           bus_o
);
  logic [NSRC-1:0][W-1:0] gated;

  // AND-OR bus: idle bus reads zero
  for (genvar g = 0; g < NSRC; g++) begin : g_gate
    assign gated[g] = src_i[g] & {W{oe_i[g]}};
  end

  always_comb begin
    bus_o = '0;
    for (int i = 0; i < NSRC; i++) bus_o = bus_o | gated[i];
  end
endmodule

// File: rtl/dp_arith.sv
module dp_arith #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_abr_i,
  input  logic         ld_acc_i,
  input  logic         sub_i,
  input  logic [W-1:0] bus_i,
  output logic [W-1:0] abr_o,
  output logic [W-1:0] acc_o,
  output logic         eqz_o
);
  logic [W-1:0] abr_q, acc_q, sum;

  // single adder; two's complement subtract via inverted operand and carry-in
  always_comb begin
    sum = abr_q + (sub_i ? ~bus_i : bus_i) + W'(sub_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      abr_q <= '0;
      acc_q <= '0;
    end else begin
      if (ld_abr_i) abr_q <= bus_i;
      if (ld_acc_i) acc_q <= sum;
    end
  end

  assign abr_o = abr_q;
  assign acc_o = acc_q;
  assign eqz_o = ~|acc_q;
endmodule

// File: rtl/dp_pc.sv
module dp_pc #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic         inc_i,
  input  logic [W-1:0] bus_i,
  output logic [W-1:0] pc_o
);
  logic [W-1:0] pc_q;

  // load has priority over increment
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pc_q <= '0;
    else if (ld_i)  pc_q <= bus_i;
    else if (inc_i) pc_q <= pc_q + W'(1);
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/dp_mem.sv
module dp_mem #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_mar_i,
  input  logic          we_i,
  input  logic [W-1:0]  bus_i,
  output logic [AW-1:0] mar_o,
  output logic [W-1:0]  rdata_o
);
  logic [AW-1:0] mar_q;
  logic [W-1:0]  mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mar_q <= '0;
    else if (ld_mar_i) mar_q <= bus_i[AW-1:0];
  end

  // storage has no reset
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[mar_q] <= bus_i;
  end

  assign mar_o   = mar_q;
  assign rdata_o = mem_q[mar_q];
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned MEM_DEPTH = 256,
  localparam int unsigned ADDR_W   = $clog2(MEM_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_abr_i,
  input  logic              sub_i,
  input  logic              ld_acc_i,
  input  logic              oe_acc_i,
  input  logic              oe_const_i,
  input  logic              const_sel_i,
  input  logic              oe_pc_i,
  input  logic              ld_pc_i,
  input  logic              inc_pc_i,
  input  logic              we_mem_i,
  input  logic              oe_port_i,
  input  logic              oe_mem_i,
  input  logic              ld_mar_i,
  input  logic [DATA_W-1:0] port_data_i,
  output logic [DATA_W-1:0] bus_o,
  output logic [DATA_W-1:0] acc_o,
  output logic [DATA_W-1:0] pc_o,
  output logic [ADDR_W-1:0] mar_o,
  output logic              eqz_o
);
  import acc_dp_pkg::*;

  logic [NUM_SRC-1:0]             oe_vec;
  logic [NUM_SRC-1:0][DATA_W-1:0] src_vec;
  logic [DATA_W-1:0]              bus, abr, acc, pc, rdata;

  always_comb begin
    oe_vec            = '0;
    oe_vec[SRC_ACC]   = oe_acc_i;
    oe_vec[SRC_CONST] = oe_const_i;
    oe_vec[SRC_PC]    = oe_pc_i;
    oe_vec[SRC_PORT]  = oe_port_i;
    oe_vec[SRC_MEM]   = oe_mem_i;
    src_vec            = '0;
    src_vec[SRC_ACC]   = acc;
    src_vec[SRC_CONST] = DATA_W'(const_sel_i);
    src_vec[SRC_PC]    = pc;
    src_vec[SRC_PORT]  = port_data_i;
    src_vec[SRC_MEM]   = rdata;
  end

  dp_bus_mux #(.W(DATA_W), .NSRC(NUM_SRC)) u_bus (
    .oe_i (oe_vec),
    .src_i(src_vec),
    .bus_o(bus)
  );

  dp_arith #(.W(DATA_W)) u_arith (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ld_abr_i(ld_abr_i),
    .ld_acc_i(ld_acc_i),
    .sub_i   (sub_i),
    .bus_i   (bus),
    .abr_o   (abr),
    .acc_o   (acc),
    .eqz_o   (eqz_o)
  );

  dp_pc #(.W(DATA_W)) u_pc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ld_i  (ld_pc_i),
    .inc_i (inc_pc_i),
    .bus_i (bus),
    .pc_o  (pc)
  );

  dp_mem #(.W(DATA_W), .DEPTH(MEM_DEPTH)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ld_mar_i(ld_mar_i),
    .we_i    (we_mem_i),
    .bus_i   (bus),
    .mar_o   (mar_o),
    .rdata_o (rdata)
  );

  assign bus_o = bus;
  assign acc_o = acc;
  assign pc_o  = pc;
endmodule

// File: rtl/acc_dp_chk.sv
module acc_dp_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         ld_abr_i,
  input logic         ld_acc_i,
  input logic         sub_i,
  input logic         ld_pc_i,
  input logic         inc_pc_i,
  input logic [4:0]   oe_vec,
  input logic [W-1:0] bus_o,
  input logic [W-1:0] abr,
  input logic [W-1:0] acc_o,
  input logic [W-1:0] pc_o,
  input logic         eqz_o
);
  // R1
  idle_bus_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_vec == '0) |-> (bus_o == '0));

  // R3
  acc_add_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_acc_i && !sub_i) |=> (acc_o == W'($past(abr) + $past(bus_o))));

  // R3
  abr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_abr_i |=> (abr == $past(bus_o)));

  // R4
  acc_sub_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_acc_i && sub_i) |=> (acc_o == W'($past(abr) - $past(bus_o))));

  // R5
  eqz_after_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_acc_i && !sub_i && W'(abr + bus_o) == '0) |=> eqz_o);

  // R6
  pc_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_pc_i |=> (pc_o == $past(bus_o)));

  // R6
  pc_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_pc_i && !ld_pc_i) |=> (pc_o == W'($past(pc_o) + W'(1))));

  // R9
  single_driver_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(oe_vec));
endmodule

bind acc_datapath acc_dp_chk #(.W(DATA_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ld_abr_i(ld_abr_i),
  .ld_acc_i(ld_acc_i),
  .sub_i   (sub_i),
  .ld_pc_i (ld_pc_i),
  .inc_pc_i(inc_pc_i),
  .oe_vec  (oe_vec),
  .bus_o   (bus_o),
  .abr     (abr),
  .acc_o   (acc_o),
  .pc_o    (pc_o),
  .eqz_o   (eqz_o)
);

// File: tb/tb_acc_datapath.sv
`timescale 1ns/1ps
module tb_acc_datapath;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ld_abr, sub, ld_acc, oe_acc, oe_const, csel, oe_pc;
  logic       ld_pc, inc_pc, we_mem, oe_port, oe_mem, ld_mar;
  logic [7:0] port;
  logic [7:0] bus, acc, pc, mar;
  logic       eqz;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  acc_datapath dut (
    .clk_i(clk), .rst_ni(rst_ni), .ld_abr_i(ld_abr), .sub_i(sub), .ld_acc_i(ld_acc),
    .oe_acc_i(oe_acc), .oe_const_i(oe_const), .const_sel_i(csel), .oe_pc_i(oe_pc),
    .ld_pc_i(ld_pc), .inc_pc_i(inc_pc), .we_mem_i(we_mem), .oe_port_i(oe_port),
    .oe_mem_i(oe_mem), .ld_mar_i(ld_mar), .port_data_i(port),
    .bus_o(bus), .acc_o(acc), .pc_o(pc), .mar_o(mar), .eqz_o(eqz)
  );

  localparam logic [12:0] LDABR = 13'h0001, SUB = 13'h0002, LDACC = 13'h0004,
                          OEACC = 13'h0008, OECON = 13'h0010, CSEL1 = 13'h0020,
                          OEPC  = 13'h0040, LDPC  = 13'h0080, INCPC = 13'h0100,
                          WEMEM = 13'h0200, OEPRT = 13'h0400, OEMEM = 13'h0800,
                          LDMAR = 13'h1000;

  typedef struct packed {
    logic [12:0] ctl;
    logic [7:0]  port;
    logic [7:0]  exp_bus;
    logic [7:0]  exp_acc;
    logic [7:0]  exp_pc;
    logic        exp_eqz;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{OECON | LDABR,          8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 4'd2},  // R2 const 0
    '{OEPRT | LDACC,          8'h05, 8'h05, 8'h05, 8'h00, 1'b0, 4'd8},  // R8 port
    '{OEACC | LDABR,          8'h00, 8'h05, 8'h05, 8'h00, 1'b0, 4'd9},  // R9 acc onto bus
    '{OEPRT | LDACC,          8'h07, 8'h07, 8'h0C, 8'h00, 1'b0, 4'd3},  // R3 add
    '{OECON | CSEL1 | LDMAR,  8'h00, 8'h01, 8'h0C, 8'h00, 1'b0, 4'd2},  // R2 const 1
    '{OEACC | WEMEM,          8'h00, 8'h0C, 8'h0C, 8'h00, 1'b0, 4'd7},  // R7 write
    '{OEACC | LDABR,          8'h00, 8'h0C, 8'h0C, 8'h00, 1'b0, 4'd3},  // R3
    '{OEMEM | SUB | LDACC,    8'h00, 8'h0C, 8'h00, 8'h00, 1'b1, 4'd5},  // R5 zero result
    '{OECON | CSEL1 | LDABR,  8'h00, 8'h01, 8'h00, 8'h00, 1'b1, 4'd2},  // R2
    '{OEMEM | SUB | LDACC,    8'h00, 8'h0C, 8'hF5, 8'h00, 1'b0, 4'd4},  // R4 borrow wrap
    '{OEACC | LDPC,           8'h00, 8'hF5, 8'hF5, 8'hF5, 1'b0, 4'd6},  // R6 load
    '{INCPC,                  8'h00, 8'h00, 8'hF5, 8'hF6, 1'b0, 4'd6},  // R6 inc, R1 idle bus
    '{OEPC | LDABR,           8'h00, 8'hF6, 8'hF5, 8'hF6, 1'b0, 4'd9},  // R9 pc onto bus
    '{OECON | CSEL1 | LDPC | INCPC, 8'h00, 8'h01, 8'hF5, 8'h01, 1'b0, 4'd6}, // R6 priority
    '{OEMEM | LDACC,          8'h00, 8'h0C, 8'h02, 8'h01, 1'b0, 4'd3}   // R3 carry wrap
  };

  task automatic drive(input logic [12:0] c, input logic [7:0] p);
    ld_abr = c[0];  sub = c[1];    ld_acc = c[2];  oe_acc = c[3];
    oe_const = c[4]; csel = c[5];  oe_pc = c[6];   ld_pc = c[7];
    inc_pc = c[8];  we_mem = c[9]; oe_port = c[10]; oe_mem = c[11];
    ld_mar = c[12]; port = p;
  endtask

  task automatic chk(input string req, input string what, input logic [7:0] got,
                     input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %02h expected %02h", req, what, got, exp);
    end
  endtask

  // drive at negedge, sample bus before edge, state after edge
  task automatic step(input logic [12:0] c, input logic [7:0] p,
                      input string req, input logic [7:0] exp_bus);
    @(negedge clk);
    drive(c, p);
    #1;
    chk(req, "bus", bus, exp_bus);
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    drive(13'h0, 8'h00);
    #12;
    // R1 reset state
    chk("R1", "acc", acc, 8'h00);
    chk("R1", "pc", pc, 8'h00);
    chk("R1", "mar", mar, 8'h00);
    chk("R1", "bus idle", bus, 8'h00);
    chk("R5", "eqz", {7'd0, eqz}, 8'h01);
    @(negedge clk);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", VECS[i].req);
      step(VECS[i].ctl, VECS[i].port, tag, VECS[i].exp_bus);
      chk(tag, "acc", acc, VECS[i].exp_acc);
      chk(tag, "pc", pc, VECS[i].exp_pc);
      chk(tag, "eqz", {7'd0, eqz}, {7'd0, VECS[i].exp_eqz});
    end

    // R6 wrap 255 -> 0
    step(OEPRT | LDPC, 8'hFF, "R6", 8'hFF);
    chk("R6", "pc load", pc, 8'hFF);
    step(INCPC, 8'h00, "R1", 8'h00);
    chk("R6", "pc wrap", pc, 8'h00);

    // R7 second address, first word untouched
    step(OEPRT | LDMAR, 8'h80, "R8", 8'h80);
    chk("R7", "mar", mar, 8'h80);
    step(OEPRT | WEMEM, 8'h3C, "R8", 8'h3C);
    step(OECON | CSEL1 | LDMAR, 8'h00, "R2", 8'h01);
    step(OEMEM, 8'h00, "R7", 8'h0C);
    step(OEPRT | LDMAR, 8'h80, "R8", 8'h80);
    step(OEMEM, 8'h00, "R7", 8'h3C);

    // R1 asynchronous reset mid-run
    @(negedge clk);
    drive(13'h0, 8'h00);
    chk("R1", "acc before", acc, 8'h02);
    #0.5;
    rst_ni = 1'b0;
    #0.5;
    chk("R1", "acc async", acc, 8'h00);
    chk("R1", "mar async", mar, 8'h00);
    chk("R1", "pc async", pc, 8'h00);
    chk("R5", "eqz async", {7'd0, eqz}, 8'h01);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule